// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block keeps a DRAM's contents alive without help from the host. A free-running interval timer asks for one row refresh every `WINDOW_CYCLES / ROWS` clock cycles. Every bank is refreshed at the same time, so a single walk over the rows of one bank covers the whole memory inside one retention window. When the `temp_hot` input is high, the spacing is halved, which gives an effective window of half the nominal length.

The host gets the memory through a request/grant pair. A refresh that falls due while the host holds the memory waits until the host drops its request. A refresh wins over a new host request. From the cycle a refresh command goes out until a fixed busy count runs out, the grant stays low. Refreshes that were postponed are counted, up to a limit. They are then issued back to back, so no row is skipped.

A pulse on `ref_cmd` comes with the row address on `ref_row`. `pass_done` marks the command for the last row, after which the row counter wraps to zero.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_cmd`, `pass_done`, `ref_busy` and `host_grant` are all low, and the first refresh command carries row 0.
- R2: Refresh commands carry row addresses that rise by one each time, from 0 up to ROWS-1, and then wrap to 0. No row is skipped or repeated, including after postponed refreshes.
- R3: `pass_done` is high exactly in the cycle of the refresh command for row ROWS-1 and in no other cycle.
- R4: With `temp_hot` low and the host idle, successive `ref_cmd` pulses are exactly WINDOW_CYCLES/ROWS cycles apart.
- R5: With `temp_hot` high and the host idle, successive `ref_cmd` pulses are exactly half that interval apart.
- R6: `ref_busy` is high for exactly BUSY_CYCLES cycles, starting in the cycle of `ref_cmd`. `host_grant` is never high while `ref_busy` is high.
- R7: With no refresh owed, `host_grant` rises in the cycle after `host_req` rises. It stays high as long as `host_req` stays high, and no refresh command is issued during that time.
- R8: Refreshes that fall due during a host access, up to OWED_MAX of them, are all issued after the host drops its request. They go out back to back, BUSY_CYCLES+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_hot | input | 1 | High temperature; halves the refresh spacing |
| host_req | input | 1 | Host asks for the memory; held for the whole access |
| host_grant | output | 1 | Host may access the memory |
| ref_cmd | output | 1 | One-cycle refresh command for all banks |
| ref_row | output | $clog2(ROWS) | Row refreshed by the current command |
| ref_busy | output | 1 | A refresh is in progress; host path blocked |
| pass_done | output | 1 | Pulses with the command for the last row |

## Verification
The bench walks past the row wrap. A counter that wrapped one row early or late, or raised the pass pulse on the wrong row, would show a gap or a repeat in the row sequence. It measures spacing only between commands after a change of `temp_hot`, so a design that ignored the flag or halved the wrong interval gives a wrong cycle count. It holds the host across more than two intervals. A scheduler that issued refreshes under a live grant, or dropped the refreshes it owed, would either pulse `ref_cmd` while the grant is high or skip rows afterwards. Checking the busy window cycle by cycle catches an off-by-one in the busy count.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package refresh_pkg;

    // Arbiter states: idle, host owns memory, refresh running.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_HOST = 2'd1,
        ARB_REF  = 2'd2
    } arb_state_t;

    // Width that can hold values 0..n (at least one bit).
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/refresh_timer.sv
// Interval timer and owed-refresh counter.
// Produces a tick every INTERVAL cycles (HOT_INTERVAL when hot).
// Each tick adds one owed refresh; each 'take' removes one.
// Assumes: INTERVAL >= 2, HOT_INTERVAL >= 1, OWED_MAX >= 1.
module refresh_timer #(
    parameter int INTERVAL     = 976,
    parameter int HOT_INTERVAL = 488,
    parameter int OWED_MAX     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic take,
    output logic due
);
    import refresh_pkg::*;

    localparam int CW = cnt_width(INTERVAL);
    localparam int OW = cnt_width(OWED_MAX);
    localparam logic [CW-1:0] LIM_COLD = CW'(INTERVAL - 1);
    localparam logic [CW-1:0] LIM_HOT  = CW'(HOT_INTERVAL - 1);
    localparam logic [OW-1:0] OWED_TOP = OW'(OWED_MAX);

    logic [CW-1:0] cnt_q;
    logic [OW-1:0] owed_q;
    logic [CW-1:0] limit;
    logic          tick;

    // Pick the active interval; '>=' lets a shortened limit take effect at once.
    always_comb begin
        limit = hot ? LIM_HOT : LIM_COLD;
        tick  = (cnt_q >= limit);
    end

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Owed refreshes: up on tick (saturating), down on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            case ({tick, take})
                2'b10:   if (owed_q != OWED_TOP) owed_q <= owed_q + 1'b1;
                2'b01:   owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    assign due = (owed_q != '0);

    // An owed refresh stays owed until it is taken (R8).
    p_due_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        due && !take |=> due);

    // Take only happens when something is owed (R8).
    p_take_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> due);

endmodule

// File: rtl/refresh_row_ctr.sv
// Row address counter shared by all banks.
// Advances by one per issued refresh and wraps after the last row.
// Assumes: ROWS >= 2.
module refresh_row_ctr #(
    parameter int ROWS = 8192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    output logic [$clog2(ROWS)-1:0] row,
    output logic                    last
);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] ROW_TOP = RW'(ROWS - 1);

    logic [RW-1:0] row_q;

    // Step the row on each refresh; wrap to zero past the top row.
    always_ff @(posedge clk) begin
        if (!rst_n)   row_q <= '0;
        else if (adv) row_q <= (row_q == ROW_TOP) ? '0 : row_q + 1'b1;
    end

    assign row  = row_q;
    assign last = (row_q == ROW_TOP);

    // Row only moves when a refresh is taken (R2).
    p_row_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_q));

    // After the top row the counter comes back to zero (R2).
    p_row_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv && last |=> row_q == '0);

endmodule

// File: rtl/refresh_arbiter.sv
// Shares the memory between the host and the refresh engine.
// Idle: an owed refresh wins over a host request.
// Host: holds the grant until host_req drops.
// Ref: blocks the host for BUSY_CYCLES cycles.
// Assumes: BUSY_CYCLES >= 2; the host holds host_req for the whole access.
module refresh_arbiter #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic due,
    output logic take,
    output logic host_grant,
    output logic busy
);
    import refresh_pkg::*;

    localparam int BW = cnt_width(BUSY_CYCLES);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES - 1);

    arb_state_t    state_q;
    arb_state_t    state_d;
    logic [BW-1:0] busy_q;

    // Next-state choice and refresh issue decision.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        case (state_q)
            ARB_IDLE: begin
                if (due) begin
                    state_d = ARB_REF;
                    take    = 1'b1;
                end else if (host_req) begin
                    state_d = ARB_HOST;
                end
            end
            ARB_HOST: if (!host_req)      state_d = ARB_IDLE;
            ARB_REF:  if (busy_q == '0)   state_d = ARB_IDLE;
            default:                      state_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Busy down-counter, loaded at refresh issue.
    always_ff @(posedge clk) begin
        if (!rst_n)                  busy_q <= '0;
        else if (take)               busy_q <= BUSY_LOAD;
        else if (busy_q != '0)       busy_q <= busy_q - 1'b1;
    end

    assign host_grant = (state_q == ARB_HOST);
    assign busy       = (state_q == ARB_REF);

    // Grant and refresh never overlap (R6).
    p_grant_busy_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_grant && busy));

    // A started refresh lasts more than one cycle (R6).
    p_busy_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // A live host access keeps its grant (R7).
    p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant && host_req |=> host_grant);

endmodule

// File: rtl/refresh_sched.sv
// Top of the refresh scheduler.
// Joins the interval timer, the row counter and the arbiter, and
// registers the refresh command, row and pass-complete outputs.
// Assumes: WINDOW_CYCLES / ROWS >= 2; ROWS >= 2; BUSY_CYCLES >= 2.
module refresh_sched #(
    parameter int ROWS          = 8192,
    parameter int WINDOW_CYCLES = 8000000,
    parameter int BUSY_CYCLES   = 4,
    parameter int OWED_MAX      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    temp_hot,
    input  logic                    host_req,
    output logic                    host_grant,
    output logic                    ref_cmd,
    output logic [$clog2(ROWS)-1:0] ref_row,
    output logic                    ref_busy,
    output logic                    pass_done
);
    localparam int RW           = $clog2(ROWS);
    localparam int INTERVAL     = WINDOW_CYCLES / ROWS;
    localparam int HOT_INTERVAL = (INTERVAL / 2 < 1) ? 1 : INTERVAL / 2;
    localparam logic [RW-1:0] ROW_TOP = RW'(ROWS - 1);

    logic          due;
    logic          take;
    logic [RW-1:0] row_now;
    logic          row_last;
    logic          cmd_q;
    logic [RW-1:0] row_q;
    logic          pass_q;

    refresh_timer #(
        .INTERVAL     (INTERVAL),
        .HOT_INTERVAL (HOT_INTERVAL),
        .OWED_MAX     (OWED_MAX)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hot   (temp_hot),
        .take  (take),
        .due   (due)
    );

    refresh_row_ctr #(
        .ROWS (ROWS)
    ) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (take),
        .row   (row_now),
        .last  (row_last)
    );

    refresh_arbiter #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .due        (due),
        .take       (take),
        .host_grant (host_grant),
        .busy       (ref_busy)
    );

    // Register the command, its row and the pass marker together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= 1'b0;
            row_q  <= '0;
            pass_q <= 1'b0;
        end else begin
            cmd_q  <= take;
            pass_q <= take && row_last;
            if (take) row_q <= row_now;
        end
    end

    assign ref_cmd   = cmd_q;
    assign ref_row   = row_q;
    assign pass_done = pass_q;

    // Pass marker only with the command for the top row (R3).
    p_pass_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> ref_cmd && ref_row == ROW_TOP);

    // Every command opens a busy window (R6).
    p_cmd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> ref_busy && !host_grant);

endmodule

// File: tb/refresh_sched_bench.sv
// Directed bench for refresh_sched: small row count, short window.
module refresh_sched_bench;

    localparam int ROWS   = 8;
    localparam int WIN    = 256;
    localparam int BUSY   = 4;
    localparam int OWMAX  = 3;
    localparam int IVL    = WIN / ROWS;   // 32
    localparam int IVL_H  = IVL / 2;      // 16
    localparam int RW     = $clog2(ROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          temp_hot = 1'b0;
    logic          host_req = 1'b0;
    logic          host_grant;
    logic          ref_cmd;
    logic [RW-1:0] ref_row;
    logic          ref_busy;
    logic          pass_done;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int exp_row = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    refresh_sched #(
        .ROWS (ROWS), .WINDOW_CYCLES (WIN), .BUSY_CYCLES (BUSY), .OWED_MAX (OWMAX)
    ) u_refresh_sched (
        .clk (clk), .rst_n (rst_n), .temp_hot (temp_hot), .host_req (host_req),
        .host_grant (host_grant), .ref_cmd (ref_cmd), .ref_row (ref_row),
        .ref_busy (ref_busy), .pass_done (pass_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Wait (at negedges) for the next refresh command; check row order,
    // pass marker and the busy window. Returns the cycle of the command.
    task automatic wait_cmd(output int at);
        @(negedge clk);
        while (!ref_cmd) @(negedge clk);
        at = cyc;
        check("R2 row order", int'(ref_row), exp_row);
        check("R3 pass marker", int'(pass_done), (exp_row == ROWS - 1) ? 1 : 0);
        exp_row = (exp_row + 1) % ROWS;
        for (int k = 0; k < BUSY; k++) begin
            if (k > 0) begin
                @(negedge clk);
                check("R3 pass only on command", int'(pass_done), 0);
            end
            check("R6 busy held", int'(ref_busy), 1);
            check("R6 grant low in refresh", int'(host_grant), 0);
        end
        @(negedge clk);
        if (!ref_cmd) check("R6 busy ends", int'(ref_busy), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 cmd at reset", int'(ref_cmd), 0);
        check("R1 busy at reset", int'(ref_busy), 0);
        check("R1 grant at reset", int'(host_grant), 0);
        check("R1 pass at reset", int'(pass_done), 0);
    endtask

    task automatic t_walk;
        int t0, t1;
        wait_cmd(t0);
        for (int i = 0; i < ROWS + 2; i++) begin
            wait_cmd(t1);
            check("R4 cold spacing", t1 - t0, IVL);
            t0 = t1;
        end
    endtask

    task automatic t_hot;
        int t0, t1;
        temp_hot = 1'b1;
        wait_cmd(t0);
        wait_cmd(t0);
        for (int i = 0; i < 3; i++) begin
            wait_cmd(t1);
            check("R5 hot spacing", t1 - t0, IVL_H);
            t0 = t1;
        end
        temp_hot = 1'b0;
        wait_cmd(t0);
        wait_cmd(t0);
        wait_cmd(t1);
        check("R4 cold spacing restored", t1 - t0, IVL);
    endtask

    task automatic t_host;
        int t0, t1, t2;
        int seen;
        wait_cmd(t0);
        host_req = 1'b1;
        @(negedge clk);
        check("R7 grant next cycle", int'(host_grant), 1);
        seen = 0;
        for (int i = 0; i < 2 * IVL + 10; i++) begin
            @(negedge clk);
            if (ref_cmd) seen++;
            if (!host_grant) begin
                check("R7 grant held", int'(host_grant), 1);
                break;
            end
        end
        check("R7 no refresh under grant", seen, 0);
        host_req = 1'b0;
        wait_cmd(t1);
        check("R8 prompt after release", (t1 - t0) > 2 * IVL ? 1 : 0, 1);
        wait_cmd(t2);
        check("R8 back-to-back spacing", t2 - t1, BUSY + 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_walk();
                t_hot();
                t_host();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule